// File: doc/BRIEF.md
# Dual Reservation Station Pool with Tag Wake-up

This block holds renamed micro-ops between decode and execution in an out-of-order core. It contains two independent pools of slots: one for arithmetic and control micro-ops, one for memory micro-ops. Each slot keeps the micro-op code, its reorder-buffer index and two source operands. Each operand is either a final value or a pending tag that names the reorder-buffer entry which will produce the value.

Decode presents one micro-op per cycle. A memory flag routes it to one of the two pools. The result bus carries a reorder-buffer index and a value. Every pending operand in either pool whose tag equals that index takes the value and stops waiting. Each pool sends at most one micro-op per cycle to its execution unit, choosing the lowest-numbered slot whose operands are both resolved, and frees that slot at the same clock edge. A flush discards everything held.

Top module: `tagwake_rs_pool`

## Requirements
- R1: A micro-op presented with `ins_valid`=1 enters the memory pool when `ins_is_mem`=1 and the arithmetic pool when `ins_is_mem`=0; the other pool is untouched.
- R2: An accepted micro-op is written into the lowest-numbered free slot of its pool, as seen before the clock edge that accepts it.
- R3: A pool's full output is 1 exactly when all SLOTS of its slots are occupied.
- R4: A slot is ready when neither operand is pending (pending flag 1 means the operand field holds a tag). Each pool dispatches at most one slot per cycle, the lowest-numbered ready one, in the cycle after the edge that made it ready; the dispatch port shows the slot number, micro-op code, reorder-buffer index and both operand values.
- R5: A dispatched slot is free after the clock edge that ends its dispatch cycle, and its micro-op is not dispatched again.
- R6: With `bc_valid`=1, every pending operand in both pools whose tag equals `bc_tag` takes `bc_data` and stops pending at that edge; operands with other tags keep waiting.
- R7: A pending operand of a micro-op inserted in the same cycle as a matching broadcast captures the broadcast value, so the micro-op never waits for a tag already delivered.
- R8: `flush`=1 empties every slot of both pools at that edge; an insertion in the same cycle is discarded.
- R9: After reset both pools are empty: full and dispatch-valid outputs are 0.
- R10: An insertion into a full pool is dropped and leaves every held slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on the edge |
| flush | input | 1 | Empty both pools |
| ins_valid | input | 1 | Micro-op presented by decode |
| ins_is_mem | input | 1 | 1 selects the memory pool, 0 the arithmetic pool |
| ins_uop | input | UOP_W | Micro-op code |
| ins_rob | input | TAG_W | Reorder-buffer index of the micro-op |
| ins_a_pend | input | 1 | Operand A waits on a tag |
| ins_a_tag | input | TAG_W | Producer index for operand A |
| ins_a_data | input | DATA_W | Value of operand A when not pending |
| ins_b_pend | input | 1 | Operand B waits on a tag |
| ins_b_tag | input | TAG_W | Producer index for operand B |
| ins_b_data | input | DATA_W | Value of operand B when not pending |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Reorder-buffer index of the result |
| bc_data | input | DATA_W | Result value |
| alu_full | output | 1 | Arithmetic pool has no free slot |
| mem_full | output | 1 | Memory pool has no free slot |
| alu_disp_valid | output | 1 | Arithmetic pool dispatches this cycle |
| alu_disp_slot | output | $clog2(SLOTS) | Slot being dispatched |
| alu_disp_uop | output | UOP_W | Dispatched micro-op code |
| alu_disp_rob | output | TAG_W | Dispatched reorder-buffer index |
| alu_disp_a | output | DATA_W | Dispatched operand A |
| alu_disp_b | output | DATA_W | Dispatched operand B |
| mem_disp_valid | output | 1 | Memory pool dispatches this cycle |
| mem_disp_slot | output | $clog2(SLOTS) | Slot being dispatched |
| mem_disp_uop | output | UOP_W | Dispatched micro-op code |
| mem_disp_rob | output | TAG_W | Dispatched reorder-buffer index |
| mem_disp_a | output | DATA_W | Dispatched operand A |
| mem_disp_b | output | DATA_W | Dispatched operand B |

## Verification
A corrupted slot shows at the dispatch port in the first cycle that slot becomes the lowest ready one. A missed wake-up shows as a dispatch that never comes. A wrong free map shows as a wrong slot number or a full flag one edge off. Because the dispatch port is driven straight from slot state, every such error is visible one cycle after the edge that caused it. The bench therefore fills a pool completely, wakes slots in a scrambled order, and compares slot number, payload and both operand values against arithmetic expectations at each of those cycles.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
   typedef enum logic {
      POOL_ALU = 1'b0,
      POOL_MEM = 1'b1
   } pool_e;

   localparam int unsigned NUM_POOLS = 2;
endpackage

// File: rtl/rsp_pick_low.sv
module rsp_pick_low #(
   parameter  int unsigned N     = 16,
   localparam int unsigned IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   generate
      if (N < 2) begin : g_bad_n
         $error("rsp_pick_low: N must be at least 2");
      end
   endgenerate

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end

   logic [N-1:0] below_mask;
   assign below_mask = (N'(1) << idx) - N'(1);

   // R4 / R2: the chosen index is requested and nothing below it is
   always_comb begin
      if (found && !$isunknown(req)) begin
         assert_pick_lowest_R4: assert (req[idx] && ((req & below_mask) == '0));
      end
   end
endmodule

// File: rtl/rsp_pool.sv
module rsp_pool #(
   parameter  int unsigned SLOTS  = 16,
   parameter  int unsigned TAG_W  = 5,
   parameter  int unsigned DATA_W = 32,
   parameter  int unsigned UOP_W  = 8,
   localparam int unsigned IDX_W  = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              ins_req,
   input  logic [UOP_W-1:0]  ins_uop,
   input  logic [TAG_W-1:0]  ins_rob,
   input  logic              ins_a_pend,
   input  logic [TAG_W-1:0]  ins_a_tag,
   input  logic [DATA_W-1:0] ins_a_data,
   input  logic              ins_b_pend,
   input  logic [TAG_W-1:0]  ins_b_tag,
   input  logic [DATA_W-1:0] ins_b_data,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_data,
   output logic              full,
   output logic              disp_valid,
   output logic [IDX_W-1:0]  disp_slot,
   output logic [UOP_W-1:0]  disp_uop,
   output logic [TAG_W-1:0]  disp_rob,
   output logic [DATA_W-1:0] disp_a,
   output logic [DATA_W-1:0] disp_b
);
   generate
      if (SLOTS < 2) begin : g_bad_slots
         $error("rsp_pool: SLOTS must be at least 2");
      end
      if (DATA_W < TAG_W) begin : g_bad_width
         $error("rsp_pool: DATA_W must hold a tag");
      end
   endgenerate

   // slot state; a pending operand keeps its tag in the low bits of its data field
   logic [SLOTS-1:0]  v_q, pa_q, pb_q;
   logic [UOP_W-1:0]  uop_q [SLOTS];
   logic [TAG_W-1:0]  rob_q [SLOTS];
   logic [DATA_W-1:0] a_q   [SLOTS];
   logic [DATA_W-1:0] b_q   [SLOTS];

   logic [SLOTS-1:0] ready, a_hit, b_hit;
   logic             free_found, ins_fire;
   logic [IDX_W-1:0] free_idx;

   always_comb begin
      for (int i = 0; i < SLOTS; i++) begin
         a_hit[i] = bc_valid && (a_q[i][TAG_W-1:0] == bc_tag);
         b_hit[i] = bc_valid && (b_q[i][TAG_W-1:0] == bc_tag);
      end
   end

   assign ready = v_q & ~pa_q & ~pb_q;
   assign full  = &v_q;

   rsp_pick_low #(.N(SLOTS)) free_pick_i (
      .req   (~v_q),
      .found (free_found),
      .idx   (free_idx)
   );

   rsp_pick_low #(.N(SLOTS)) ready_pick_i (
      .req   (ready),
      .found (disp_valid),
      .idx   (disp_slot)
   );

   assign ins_fire = ins_req && free_found && !flush;

   // capture a result that arrives together with the insertion
   logic              a_byp, b_byp, a_in_pend, b_in_pend;
   logic [DATA_W-1:0] a_in, b_in;

   assign a_byp     = ins_a_pend && bc_valid && (bc_tag == ins_a_tag);
   assign b_byp     = ins_b_pend && bc_valid && (bc_tag == ins_b_tag);
   assign a_in_pend = ins_a_pend && !a_byp;
   assign b_in_pend = ins_b_pend && !b_byp;
   assign a_in      = !ins_a_pend ? ins_a_data : (a_byp ? bc_data : DATA_W'(ins_a_tag));
   assign b_in      = !ins_b_pend ? ins_b_data : (b_byp ? bc_data : DATA_W'(ins_b_tag));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q  <= '0;
         pa_q <= '0;
         pb_q <= '0;
         for (int i = 0; i < SLOTS; i++) begin
            uop_q[i] <= '0;
            rob_q[i] <= '0;
            a_q[i]   <= '0;
            b_q[i]   <= '0;
         end
      end else if (flush) begin
         v_q  <= '0;
         pa_q <= '0;
         pb_q <= '0;
      end else begin
         for (int i = 0; i < SLOTS; i++) begin
            if (disp_valid && (disp_slot == IDX_W'(i))) begin
               v_q[i] <= 1'b0;
            end else if (ins_fire && (free_idx == IDX_W'(i))) begin
               v_q[i]   <= 1'b1;
               uop_q[i] <= ins_uop;
               rob_q[i] <= ins_rob;
               pa_q[i]  <= a_in_pend;
               pb_q[i]  <= b_in_pend;
               a_q[i]   <= a_in;
               b_q[i]   <= b_in;
            end else if (v_q[i]) begin
               if (pa_q[i] && a_hit[i]) begin
                  pa_q[i] <= 1'b0;
                  a_q[i]  <= bc_data;
               end
               if (pb_q[i] && b_hit[i]) begin
                  pb_q[i] <= 1'b0;
                  b_q[i]  <= bc_data;
               end
            end
         end
      end
   end

   assign disp_uop = uop_q[disp_slot];
   assign disp_rob = rob_q[disp_slot];
   assign disp_a   = a_q[disp_slot];
   assign disp_b   = b_q[disp_slot];

   // ---------------- assertions ----------------
   assert_free_on_dispatch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid && !flush |=> !v_q[$past(disp_slot)]);

   assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (v_q == '0));

   assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ins_req && full && !flush |=>
         ($countones(v_q) == $past($countones(v_q)) - int'($past(disp_valid))));

   assert_insert_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ins_req && !full && !flush |=> v_q[$past(free_idx)]);

   assert_same_cycle_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ins_fire && a_byp |=> !pa_q[$past(free_idx)] && (a_q[$past(free_idx)] == $past(bc_data)));

   generate
      for (genvar gi = 0; gi < SLOTS; gi++) begin : g_wake_chk
         assert_wake_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
            v_q[gi] && pa_q[gi] && a_hit[gi] && !flush |=> !pa_q[gi] && (a_q[gi] == $past(bc_data)));
         assert_wake_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
            v_q[gi] && pb_q[gi] && b_hit[gi] && !flush |=> !pb_q[gi] && (b_q[gi] == $past(bc_data)));
      end
   endgenerate
endmodule

// File: rtl/tagwake_rs_pool.sv
module tagwake_rs_pool
   import rsp_pkg::*;
#(
   parameter  int unsigned SLOTS  = 16,
   parameter  int unsigned TAG_W  = 5,
   parameter  int unsigned DATA_W = 32,
   parameter  int unsigned UOP_W  = 8,
   localparam int unsigned IDX_W  = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              ins_valid,
   input  logic              ins_is_mem,
   input  logic [UOP_W-1:0]  ins_uop,
   input  logic [TAG_W-1:0]  ins_rob,
   input  logic              ins_a_pend,
   input  logic [TAG_W-1:0]  ins_a_tag,
   input  logic [DATA_W-1:0] ins_a_data,
   input  logic              ins_b_pend,
   input  logic [TAG_W-1:0]  ins_b_tag,
   input  logic [DATA_W-1:0] ins_b_data,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_data,
   output logic              alu_full,
   output logic              mem_full,
   output logic              alu_disp_valid,
   output logic [IDX_W-1:0]  alu_disp_slot,
   output logic [UOP_W-1:0]  alu_disp_uop,
   output logic [TAG_W-1:0]  alu_disp_rob,
   output logic [DATA_W-1:0] alu_disp_a,
   output logic [DATA_W-1:0] alu_disp_b,
   output logic              mem_disp_valid,
   output logic [IDX_W-1:0]  mem_disp_slot,
   output logic [UOP_W-1:0]  mem_disp_uop,
   output logic [TAG_W-1:0]  mem_disp_rob,
   output logic [DATA_W-1:0] mem_disp_a,
   output logic [DATA_W-1:0] mem_disp_b
);
   logic              p_full [NUM_POOLS];
   logic              p_dv   [NUM_POOLS];
   logic [IDX_W-1:0]  p_slot [NUM_POOLS];
   logic [UOP_W-1:0]  p_uop  [NUM_POOLS];
   logic [TAG_W-1:0]  p_rob  [NUM_POOLS];
   logic [DATA_W-1:0] p_a    [NUM_POOLS];
   logic [DATA_W-1:0] p_b    [NUM_POOLS];

   generate
      for (genvar gp = 0; gp < NUM_POOLS; gp++) begin : g_pool
         // R1: route by the memory flag
         logic sel;
         assign sel = ins_valid && (pool_e'(ins_is_mem) == pool_e'(gp));

         rsp_pool #(
            .SLOTS (SLOTS), .TAG_W (TAG_W), .DATA_W (DATA_W), .UOP_W (UOP_W)
         ) pool_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush      (flush),
            .ins_req    (sel),
            .ins_uop    (ins_uop),
            .ins_rob    (ins_rob),
            .ins_a_pend (ins_a_pend),
            .ins_a_tag  (ins_a_tag),
            .ins_a_data (ins_a_data),
            .ins_b_pend (ins_b_pend),
            .ins_b_tag  (ins_b_tag),
            .ins_b_data (ins_b_data),
            .bc_valid   (bc_valid),
            .bc_tag     (bc_tag),
            .bc_data    (bc_data),
            .full       (p_full[gp]),
            .disp_valid (p_dv[gp]),
            .disp_slot  (p_slot[gp]),
            .disp_uop   (p_uop[gp]),
            .disp_rob   (p_rob[gp]),
            .disp_a     (p_a[gp]),
            .disp_b     (p_b[gp])
         );
      end
   endgenerate

   assign alu_full       = p_full[POOL_ALU];
   assign alu_disp_valid = p_dv[POOL_ALU];
   assign alu_disp_slot  = p_slot[POOL_ALU];
   assign alu_disp_uop   = p_uop[POOL_ALU];
   assign alu_disp_rob   = p_rob[POOL_ALU];
   assign alu_disp_a     = p_a[POOL_ALU];
   assign alu_disp_b     = p_b[POOL_ALU];

   assign mem_full       = p_full[POOL_MEM];
   assign mem_disp_valid = p_dv[POOL_MEM];
   assign mem_disp_slot  = p_slot[POOL_MEM];
   assign mem_disp_uop   = p_uop[POOL_MEM];
   assign mem_disp_rob   = p_rob[POOL_MEM];
   assign mem_disp_a     = p_a[POOL_MEM];
   assign mem_disp_b     = p_b[POOL_MEM];

   // R1: an insertion never lands in the pool it was not routed to
   assert_route_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ins_valid && !ins_is_mem && !flush && !mem_disp_valid |=> $stable(mem_full));
endmodule

// File: tb/tagwake_rs_pool_tb.sv
module tagwake_rs_pool_tb_top;
   localparam int unsigned SLOTS  = 16;
   localparam int unsigned TAG_W  = 5;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned UOP_W  = 8;
   localparam int unsigned IDX_W  = $clog2(SLOTS);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0;
   logic ins_valid = 1'b0, ins_is_mem = 1'b0;
   logic [UOP_W-1:0]  ins_uop = '0;
   logic [TAG_W-1:0]  ins_rob = '0;
   logic              ins_a_pend = 1'b0, ins_b_pend = 1'b0;
   logic [TAG_W-1:0]  ins_a_tag = '0, ins_b_tag = '0;
   logic [DATA_W-1:0] ins_a_data = '0, ins_b_data = '0;
   logic              bc_valid = 1'b0;
   logic [TAG_W-1:0]  bc_tag = '0;
   logic [DATA_W-1:0] bc_data = '0;

   logic              alu_full, mem_full, alu_disp_valid, mem_disp_valid;
   logic [IDX_W-1:0]  alu_disp_slot, mem_disp_slot;
   logic [UOP_W-1:0]  alu_disp_uop, mem_disp_uop;
   logic [TAG_W-1:0]  alu_disp_rob, mem_disp_rob;
   logic [DATA_W-1:0] alu_disp_a, alu_disp_b, mem_disp_a, mem_disp_b;

   always #10 clk = ~clk;   // 50 MHz

   tagwake_rs_pool #(.SLOTS(SLOTS), .TAG_W(TAG_W), .DATA_W(DATA_W), .UOP_W(UOP_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .ins_valid(ins_valid), .ins_is_mem(ins_is_mem), .ins_uop(ins_uop), .ins_rob(ins_rob),
      .ins_a_pend(ins_a_pend), .ins_a_tag(ins_a_tag), .ins_a_data(ins_a_data),
      .ins_b_pend(ins_b_pend), .ins_b_tag(ins_b_tag), .ins_b_data(ins_b_data),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
      .alu_full(alu_full), .mem_full(mem_full),
      .alu_disp_valid(alu_disp_valid), .alu_disp_slot(alu_disp_slot), .alu_disp_uop(alu_disp_uop),
      .alu_disp_rob(alu_disp_rob), .alu_disp_a(alu_disp_a), .alu_disp_b(alu_disp_b),
      .mem_disp_valid(mem_disp_valid), .mem_disp_slot(mem_disp_slot), .mem_disp_uop(mem_disp_uop),
      .mem_disp_rob(mem_disp_rob), .mem_disp_a(mem_disp_a), .mem_disp_b(mem_disp_b)
   );

   int n_cmp = 0;
   int n_bad = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one clock edge; inputs return to idle 1 ns after it
   task automatic tick();
      @(posedge clk);
      #1;
      ins_valid = 1'b0; bc_valid = 1'b0; flush = 1'b0;
   endtask

   task automatic put(input logic mem, input logic [UOP_W-1:0] uop, input logic [TAG_W-1:0] rob,
                      input logic ap, input logic [TAG_W-1:0] at, input logic [DATA_W-1:0] ad,
                      input logic bp, input logic [TAG_W-1:0] bt, input logic [DATA_W-1:0] bd);
      ins_valid = 1'b1; ins_is_mem = mem; ins_uop = uop; ins_rob = rob;
      ins_a_pend = ap; ins_a_tag = at; ins_a_data = ad;
      ins_b_pend = bp; ins_b_tag = bt; ins_b_data = bd;
   endtask

   task automatic bcast(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] d);
      bc_valid = 1'b1; bc_tag = t; bc_data = d;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R9: empty after reset
      chk("R9 alu_full", alu_full, 0);
      chk("R9 mem_full", mem_full, 0);
      chk("R9 alu_dv", alu_disp_valid, 0);
      chk("R9 mem_dv", mem_disp_valid, 0);

      // R1/R4: ready arithmetic op goes to arithmetic pool only
      put(0, 8'h11, 5'd3, 0, 0, 32'd10, 0, 0, 32'd20);
      tick();
      chk("R1 alu_dv", alu_disp_valid, 1);
      chk("R1 mem_dv", mem_disp_valid, 0);
      chk("R4 alu uop", alu_disp_uop, 8'h11);
      chk("R4 alu rob", alu_disp_rob, 5'd3);
      chk("R4 alu a", alu_disp_a, 10);
      chk("R4 alu b", alu_disp_b, 20);
      chk("R2 alu slot", alu_disp_slot, 0);
      tick();
      chk("R5 alu freed", alu_disp_valid, 0);

      // R1: memory op goes to memory pool only
      put(1, 8'h22, 5'd4, 0, 0, 32'd5, 0, 0, 32'd6);
      tick();
      chk("R1 mem_dv", mem_disp_valid, 1);
      chk("R1 alu_dv idle", alu_disp_valid, 0);
      chk("R1 mem uop", mem_disp_uop, 8'h22);
      tick();
      chk("R5 mem freed", mem_disp_valid, 0);

      // R3/R10/R6/R5: fill arithmetic pool, then wake in scrambled order
      for (int i = 0; i < SLOTS; i++) begin
         put(0, UOP_W'(32 + i), TAG_W'(i), 1, TAG_W'(i), 0, 0, 0, DATA_W'(100 + i));
         tick();
      end
      chk("R3 alu_full", alu_full, 1);
      chk("R3 mem_full", mem_full, 0);
      chk("R4 none ready", alu_disp_valid, 0);
      put(0, 8'd99, 5'd30, 0, 0, 32'd1, 0, 0, 32'd2);
      tick();
      chk("R10 dropped", alu_disp_valid, 0);
      chk("R10 still full", alu_full, 1);
      for (int k = 0; k < SLOTS; k++) begin
         int t;
         t = (k * 5) % SLOTS;
         bcast(TAG_W'(t), DATA_W'(t * 7));
         tick();
         chk("R6 dv", alu_disp_valid, 1);
         chk("R6 slot", alu_disp_slot, t);
         chk("R10 uop kept", alu_disp_uop, 32 + t);
         chk("R6 a value", alu_disp_a, t * 7);
         chk("R10 b kept", alu_disp_b, 100 + t);
         chk("R3 full before free", alu_full, 1'(k == 0));
         tick();
         chk("R5 no repeat", alu_disp_valid, 0);
         chk("R3 not full", alu_full, 0);
      end

      // R2: refill goes to lowest free slots
      for (int i = 0; i < 4; i++) begin
         put(0, UOP_W'(i), TAG_W'(i), 1, TAG_W'(20 + i), 0, 0, 0, 0);
         tick();
      end
      bcast(5'd21, 32'h21); tick();
      chk("R2 wake slot1", alu_disp_slot, 1);
      bcast(5'd23, 32'h23); tick();
      chk("R4 slot3", alu_disp_slot, 3);
      put(0, 8'd24, 0, 1, 5'd24, 0, 0, 0, 0); tick();
      put(0, 8'd25, 0, 1, 5'd25, 0, 0, 0, 0); tick();
      put(0, 8'd26, 0, 1, 5'd26, 0, 0, 0, 0); tick();
      bcast(5'd26, 32'h26); tick();
      chk("R2 third into slot4", alu_disp_slot, 4);
      bcast(5'd25, 32'h25); tick();
      chk("R2 second into slot3", alu_disp_slot, 3);
      bcast(5'd24, 32'h24); tick();
      chk("R2 first into slot1", alu_disp_slot, 1);
      chk("R2 uop", alu_disp_uop, 24);
      flush = 1'b1; tick();

      // R4: several ready at once dispatch lowest first, one per cycle
      for (int i = 0; i < 3; i++) begin
         put(0, UOP_W'(50 + i), 0, 1, 5'd12, 0, 0, 0, 0);
         tick();
      end
      bcast(5'd12, 32'hC);
      tick();
      for (int i = 0; i < 3; i++) begin
         chk("R4 order dv", alu_disp_valid, 1);
         chk("R4 order slot", alu_disp_slot, i);
         chk("R4 order uop", alu_disp_uop, 50 + i);
         tick();
      end
      chk("R4 drained", alu_disp_valid, 0);

      // R6: one broadcast wakes both pools; other tags do not
      put(0, 8'h61, 5'd1, 1, 5'd7, 0, 0, 0, 32'd3); tick();
      put(1, 8'h62, 5'd2, 0, 0, 32'd4, 1, 5'd7, 0); tick();
      bcast(5'd8, 32'hBAD); tick();
      chk("R6 other tag alu", alu_disp_valid, 0);
      chk("R6 other tag mem", mem_disp_valid, 0);
      bcast(5'd7, 32'hABCD); tick();
      chk("R6 alu dv", alu_disp_valid, 1);
      chk("R6 alu a", alu_disp_a, 32'hABCD);
      chk("R6 mem dv", mem_disp_valid, 1);
      chk("R6 mem b", mem_disp_b, 32'hABCD);
      chk("R6 mem a", mem_disp_a, 4);
      tick();

      // R7: wake in the insertion cycle
      put(0, 8'h70, 5'd9, 1, 5'd9, 0, 0, 0, 32'd1);
      bcast(5'd9, 32'h55);
      tick();
      chk("R7 dv", alu_disp_valid, 1);
      chk("R7 a", alu_disp_a, 32'h55);
      tick();

      // R8: flush empties both pools and beats an insertion
      put(0, 8'h80, 0, 1, 5'd3, 0, 0, 0, 0); tick();
      put(1, 8'h81, 0, 1, 5'd3, 0, 0, 0, 0); tick();
      flush = 1'b1; tick();
      bcast(5'd3, 32'h3); tick();
      chk("R8 alu empty", alu_disp_valid, 0);
      chk("R8 mem empty", mem_disp_valid, 0);
      put(0, 8'h82, 0, 0, 0, 32'd1, 0, 0, 32'd1);
      flush = 1'b1;
      tick();
      chk("R8 insert dropped", alu_disp_valid, 0);
      chk("R8 not full", alu_full, 0);

      summary();
      $finish;
   end
endmodule